// File: doc/BRIEF.md
# Floating-Point Conditional Debug Trap

This block decides whether a conditional debug-trap instruction stops the core. The instruction names one floating-point condition. The block tests that condition against the current comparison flags (negative, zero, infinity, not-a-number), or for the error condition against the accumulated error flags. A valid strobe marks the cycle in which the instruction executes. If the condition holds, the core goes into a halted state on the next clock edge and waits there for a debug-resume pulse. If it does not hold, execution continues and nothing changes.

Fourteen of the conditions are ordered comparisons that are not meant to meet a NaN. Call them NaN-sensitive. When such a condition is executed while the NaN flag is set, the block raises two sticky exception flags: an invalid-operation flag and an unordered-compare flag. Both flags stay set until reset, or until the clear input is pulsed. The comparison flags are inputs only, and the block never writes them.

Top module: `fpdt_trap`

## Requirements
- R1: After a synchronous active-low reset, `halted`, `siop_sticky` and `uncc_sticky` are all 0.
- R2: `cond_true` follows the select code with no clock delay. Code 0 (EQ) gives Z, 1 (NE) gives !Z, 2 (MI) gives N and 3 (PL) gives !N.
- R3: Code 4 (GE) gives !(NAN|(N&!Z)), 6 (GT) gives !(NAN|Z|N), 8 (LE) gives !(NAN|!(N|Z)), 10 (LT) gives !(NAN|Z|!N) and 12 (GL) gives !(NAN|Z). Each odd code from 5 to 13 gives the complement of the even code just below it.
- R4: Codes 14 (GLE) and 16 (OR) give !NAN. Codes 15 (NGLE) and 17 (UN) give NAN. Code 18 (INF) gives I and code 19 (NINF) gives !I.
- R5: Code 20 (ERR) gives the OR of the six error inputs. It does not depend on N, Z, I or NAN.
- R6: Codes 21 to 31 give `cond_true`=0, never halt the core and never set a sticky flag.
- R7: An accepted instruction is one where `instr_valid`=1 while `halted`=0. If the condition is true, `halted` becomes 1 on the next edge. If it is false, `halted` stays 0.
- R8: While `halted`=1, instruction strobes have no effect on `halted` or on the sticky flags. A `resume` pulse clears `halted` on the next edge.
- R9: An accepted instruction whose code is in 4..15 or 18..19, executed with NAN=1, sets both `siop_sticky` and `uncc_sticky` on the next edge. Codes 0..3, 16, 17 and 20 never set the flags. With NAN=0, no code sets them.
- R10: `sticky_clr` clears both sticky flags on the next edge. If a set occurs in the same cycle, the set takes priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| instr_valid | input | 1 | Trap instruction executes this cycle |
| cond_sel | input | 5 | Condition select code |
| flag_n | input | 1 | Negative flag |
| flag_z | input | 1 | Zero flag |
| flag_i | input | 1 | Infinity flag |
| flag_nan | input | 1 | Not-a-number flag |
| err_uncc | input | 1 | Error register: unordered compare |
| err_snan | input | 1 | Error register: signalling NaN |
| err_operr | input | 1 | Error register: operand error |
| err_ovf | input | 1 | Error register: overflow |
| err_unf | input | 1 | Error register: underflow |
| err_dz | input | 1 | Error register: divide by zero |
| sticky_clr | input | 1 | Clear both sticky flags |
| resume | input | 1 | Debug-resume pulse |
| cond_true | output | 1 | Selected condition evaluates true |
| halted | output | 1 | Core is held in debug state |
| siop_sticky | output | 1 | Sticky invalid-operation flag |
| uncc_sticky | output | 1 | Sticky unordered-compare flag |

## Verification
The bench sweeps every select code against all sixteen combinations of the comparison flags, and it also runs the ERR code against all 64 error patterns. A slip in a NaN term would make an ordered compare come out true on a NaN, and a swap of complement pairs would invert whole rows. An error condition wired to the comparison flags would also show up in this sweep. After each trap the bench checks that a strobe sent while halted leaves the sticky flags and the halted state alone. A design that kept accepting strobes while halted would re-arm the flags. The bench also checks that the unused codes 21..31 stay silent, and that a set arriving together with a clear wins. A design with a clear-first priority would lose the exception.

// File: rtl/fpdt_pkg.sv
// Package: shared widths, condition codes and flag groupings for the trap.
// Assumes: select codes outside the enumerated set are treated as false.
package fpdt_pkg;
    localparam int SEL_W   = 5;
    localparam int NSTICKY = 2;
    localparam int ERR_W   = 6;

    typedef enum logic [SEL_W-1:0] {
        C_EQ  = 5'd0,  C_NE   = 5'd1,  C_MI  = 5'd2,  C_PL   = 5'd3,
        C_GE  = 5'd4,  C_NGE  = 5'd5,  C_GT  = 5'd6,  C_NGT  = 5'd7,
        C_LE  = 5'd8,  C_NLE  = 5'd9,  C_LT  = 5'd10, C_NLT  = 5'd11,
        C_GL  = 5'd12, C_NGL  = 5'd13, C_GLE = 5'd14, C_NGLE = 5'd15,
        C_OR  = 5'd16, C_UN   = 5'd17, C_INF = 5'd18, C_NINF = 5'd19,
        C_ERR = 5'd20
    } cond_e;

    localparam logic [SEL_W-1:0] LAST_CODE = C_ERR;

    typedef struct packed {
        logic n;
        logic z;
        logic i;
        logic nan;
    } cc_flags_t;

    // Bit positions of the sticky vector
    localparam int STK_SIOP = 0;
    localparam int STK_UNCC = 1;
endpackage

// File: rtl/fpdt_cond_eval.sv
// Module: combinational evaluator for the selected floating-point condition.
// Also reports whether the code is NaN-sensitive, meaning it should raise
// exceptions when NAN is set.
// Assumes: codes above LAST_CODE evaluate false and are not NaN-sensitive.
module fpdt_cond_eval
    import fpdt_pkg::*;
(
    input  logic [SEL_W-1:0] sel,
    input  cc_flags_t        cc,
    input  logic [ERR_W-1:0] err,
    output logic             cond_true,
    output logic             nan_sens
);
    logic ge_b, gt_b, le_b, lt_b, gl_b;

    // Base predicates of the ordered comparisons; the odd codes negate them
    always_comb begin
        ge_b = !(cc.nan | (cc.n & !cc.z));
        gt_b = !(cc.nan | cc.z | cc.n);
        le_b = !(cc.nan | !(cc.n | cc.z));
        lt_b = !(cc.nan | cc.z | !cc.n);
        gl_b = !(cc.nan | cc.z);
    end

    // Select the condition result and its NaN-sensitivity
    always_comb begin
        cond_true = 1'b0;
        nan_sens  = 1'b0;
        case (sel)
            C_EQ:   cond_true = cc.z;
            C_NE:   cond_true = !cc.z;
            C_MI:   cond_true = cc.n;
            C_PL:   cond_true = !cc.n;
            C_GE:   begin cond_true = ge_b;    nan_sens = 1'b1; end
            C_NGE:  begin cond_true = !ge_b;   nan_sens = 1'b1; end
            C_GT:   begin cond_true = gt_b;    nan_sens = 1'b1; end
            C_NGT:  begin cond_true = !gt_b;   nan_sens = 1'b1; end
            C_LE:   begin cond_true = le_b;    nan_sens = 1'b1; end
            C_NLE:  begin cond_true = !le_b;   nan_sens = 1'b1; end
            C_LT:   begin cond_true = lt_b;    nan_sens = 1'b1; end
            C_NLT:  begin cond_true = !lt_b;   nan_sens = 1'b1; end
            C_GL:   begin cond_true = gl_b;    nan_sens = 1'b1; end
            C_NGL:  begin cond_true = !gl_b;   nan_sens = 1'b1; end
            C_GLE:  begin cond_true = !cc.nan; nan_sens = 1'b1; end
            C_NGLE: begin cond_true = cc.nan;  nan_sens = 1'b1; end
            C_OR:   cond_true = !cc.nan;
            C_UN:   cond_true = cc.nan;
            C_INF:  begin cond_true = cc.i;    nan_sens = 1'b1; end
            C_NINF: begin cond_true = !cc.i;   nan_sens = 1'b1; end
            C_ERR:  cond_true = |err;
            default: begin cond_true = 1'b0; nan_sens = 1'b0; end
        endcase
    end

    // Unused codes stay silent (R6)
    always_comb begin
        if (sel > LAST_CODE)
            p_unused_silent_r6: assert (!cond_true && !nan_sens);
    end
endmodule

// File: rtl/fpdt_halt_ctrl.sv
// Module: holds the halted state of the core for the conditional debug trap.
// Assumes: resume is a one-cycle pulse; strobes that arrive while halted are
// dropped by the caller through the accept output.
module fpdt_halt_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic instr_valid,
    input  logic cond_true,
    input  logic resume,
    output logic accept,
    output logic halted
);
    // An instruction counts only while the core is running
    always_comb accept = instr_valid && !halted;

    // Enter halt on a true accepted trap; leave on resume
    always_ff @(posedge clk) begin
        if (!rst_n)
            halted <= 1'b0;
        else if (halted && resume)
            halted <= 1'b0;
        else if (accept && cond_true)
            halted <= 1'b1;
    end

    p_enter_halt_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && !halted && cond_true) |=> halted);
    p_no_false_halt_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!halted && !(instr_valid && cond_true)) |=> !halted);
    p_resume_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (halted && resume) |=> !halted);
    p_halt_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (halted && !resume) |=> halted);
endmodule

// File: rtl/fpdt_sticky_flags.sv
// Module: a bank of sticky flags with a shared set request and a shared clear.
// Assumes: if set and clear arrive in the same cycle, set has priority so that
// no exception is lost.
module fpdt_sticky_flags #(
    parameter int NFLAG = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NFLAG-1:0] set,
    input  logic             clr,
    output logic [NFLAG-1:0] flags
);
    for (genvar k = 0; k < NFLAG; k++) begin : g_flag
        // One flag: set dominates clear, holds otherwise
        always_ff @(posedge clk) begin
            if (!rst_n)
                flags[k] <= 1'b0;
            else if (set[k])
                flags[k] <= 1'b1;
            else if (clr)
                flags[k] <= 1'b0;
        end

        p_set_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
            set[k] |=> flags[k]);
        p_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
            (clr && !set[k]) |=> !flags[k]);
        p_sticky_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (flags[k] && !clr) |=> flags[k]);
    end
endmodule

// File: rtl/fpdt_trap.sv
// Module: top of the floating-point conditional debug trap. Evaluates the
// selected condition, halts the core on a true accepted trap and raises the
// sticky exception flags when a NaN-sensitive code meets a NaN.
// Assumes: the flag inputs are stable in the cycle that instr_valid is high.
module fpdt_trap
    import fpdt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             instr_valid,
    input  logic [SEL_W-1:0] cond_sel,
    input  logic             flag_n,
    input  logic             flag_z,
    input  logic             flag_i,
    input  logic             flag_nan,
    input  logic             err_uncc,
    input  logic             err_snan,
    input  logic             err_operr,
    input  logic             err_ovf,
    input  logic             err_unf,
    input  logic             err_dz,
    input  logic             sticky_clr,
    input  logic             resume,
    output logic             cond_true,
    output logic             halted,
    output logic             siop_sticky,
    output logic             uncc_sticky
);
    cc_flags_t          cc;
    logic [ERR_W-1:0]   err;
    logic               nan_sens;
    logic               accept;
    logic               raise;
    logic [NSTICKY-1:0] stk_set;
    logic [NSTICKY-1:0] stk_q;

    // Group the flag pins into the package types
    always_comb begin
        cc  = '{n: flag_n, z: flag_z, i: flag_i, nan: flag_nan};
        err = {err_uncc, err_snan, err_operr, err_ovf, err_unf, err_dz};
    end

    fpdt_cond_eval u_eval (
        .sel       (cond_sel),
        .cc        (cc),
        .err       (err),
        .cond_true (cond_true),
        .nan_sens  (nan_sens)
    );

    fpdt_halt_ctrl u_halt (
        .clk         (clk),
        .rst_n       (rst_n),
        .instr_valid (instr_valid),
        .cond_true   (cond_true),
        .resume      (resume),
        .accept      (accept),
        .halted      (halted)
    );

    // Raise both exception flags when an accepted NaN-sensitive code meets NaN
    always_comb begin
        raise   = accept && nan_sens && flag_nan;
        stk_set = {NSTICKY{raise}};
    end

    fpdt_sticky_flags #(.NFLAG(NSTICKY)) u_sticky (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (stk_set),
        .clr   (sticky_clr),
        .flags (stk_q)
    );

    // Map the sticky vector onto the named outputs
    always_comb begin
        siop_sticky = stk_q[STK_SIOP];
        uncc_sticky = stk_q[STK_UNCC];
    end

    p_halt_blocks_flags_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (halted && !sticky_clr && !siop_sticky) |=> !siop_sticky);
    p_no_flag_without_nan_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag_nan && !siop_sticky && !sticky_clr) |=> !siop_sticky);
endmodule

// File: tb/fpdt_trap_tb.sv
// Bench: sweeps every select code against the comparison flags and the error
// patterns, and checks the halt, resume and sticky behaviour after each trap.
module fpdt_trap_tb_top;
    localparam time CLK_PERIOD = 10ns;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       instr_valid = 1'b0;
    logic [4:0] cond_sel = '0;
    logic       flag_n = 0, flag_z = 0, flag_i = 0, flag_nan = 0;
    logic [5:0] errv = '0;
    logic       sticky_clr = 1'b0;
    logic       resume = 1'b0;
    logic       cond_true, halted, siop_sticky, uncc_sticky;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fpdt_trap dut_i (
        .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .cond_sel(cond_sel),
        .flag_n(flag_n), .flag_z(flag_z), .flag_i(flag_i), .flag_nan(flag_nan),
        .err_uncc(errv[5]), .err_snan(errv[4]), .err_operr(errv[3]),
        .err_ovf(errv[2]), .err_unf(errv[1]), .err_dz(errv[0]),
        .sticky_clr(sticky_clr), .resume(resume),
        .cond_true(cond_true), .halted(halted),
        .siop_sticky(siop_sticky), .uncc_sticky(uncc_sticky)
    );

    function automatic bit exp_true(int c, bit n, bit z, bit i, bit nan, bit [5:0] e);
        bit base;
        case (c)
            0: return z;
            1: return !z;
            2: return n;
            3: return !n;
            4, 5:   base = !(nan || (n && !z));
            6, 7:   base = !(nan || z || n);
            8, 9:   base = !(nan || !(n || z));
            10, 11: base = !(nan || z || !n);
            12, 13: base = !(nan || z);
            14, 16: return !nan;
            15, 17: return nan;
            18: return i;
            19: return !i;
            20: return e != 0;
            default: return 0;
        endcase
        return (c % 2 == 0) ? base : !base;
    endfunction

    function automatic bit exp_sens(int c);
        return (c >= 4 && c <= 15) || c == 18 || c == 19;
    endfunction

    task automatic check(string req, string what, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic string tag_for(int c);
        if (c <= 3) return "R2";
        if (c <= 13) return "R3";
        if (c <= 19) return "R4";
        if (c == 20) return "R5";
        return "R6";
    endfunction

    task automatic one_trap(int c, bit [3:0] f, bit [5:0] e);
        bit et, es;
        @(negedge clk);
        cond_sel = 5'(c);
        {flag_n, flag_z, flag_i, flag_nan} = f;
        errv = e;
        instr_valid = 1'b1;
        et = exp_true(c, f[3], f[2], f[1], f[0], e);
        es = exp_sens(c) && f[0];
        #1;
        check(tag_for(c), $sformatf("cond_true code %0d flags %b err %b", c, f, e),
              cond_true, et);
        @(negedge clk);
        instr_valid = 1'b0;
        check("R7", $sformatf("halted after code %0d flags %b", c, f), halted, et);
        check("R9", $sformatf("siop after code %0d flags %b", c, f), siop_sticky, es);
        check("R9", $sformatf("uncc after code %0d flags %b", c, f), uncc_sticky, es);
        // clear sticky flags
        sticky_clr = 1'b1;
        @(negedge clk);
        sticky_clr = 1'b0;
        check("R10", "sticky cleared", {siop_sticky, uncc_sticky}, 0);
        if (et) begin
            // strobe a NaN-sensitive true-or-false trap while halted: ignored
            cond_sel = 5'd15; flag_nan = 1'b1; instr_valid = 1'b1;
            @(negedge clk);
            instr_valid = 1'b0;
            check("R8", "halted held under strobe", halted, 1);
            check("R8", "sticky untouched while halted", siop_sticky, 0);
            resume = 1'b1;
            @(negedge clk);
            resume = 1'b0;
            check("R8", "resume clears halted", halted, 0);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1", "halted at reset", halted, 0);
        check("R1", "siop at reset", siop_sticky, 0);
        check("R1", "uncc at reset", uncc_sticky, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "state after reset release", {halted, siop_sticky, uncc_sticky}, 0);
        for (int c = 0; c < 32; c++) begin
            for (int f = 0; f < 16; f++) begin
                one_trap(c, 4'(f), 6'((c * 7 + f * 5) % 64));
            end
        end
        // ERR code against every error pattern, with a NaN on the compare flags
        for (int e = 0; e < 64; e++) begin
            one_trap(20, 4'b0001, 6'(e));
            one_trap(20, 4'b1110, 6'(e));
        end
        // set and clear in the same cycle: set wins (R10)
        @(negedge clk);
        cond_sel = 5'd6; {flag_n, flag_z, flag_i, flag_nan} = 4'b0001;
        instr_valid = 1'b1; sticky_clr = 1'b1;
        @(negedge clk);
        instr_valid = 1'b0; sticky_clr = 1'b0;
        check("R10", "set wins over clear siop", siop_sticky, 1);
        check("R10", "set wins over clear uncc", uncc_sticky, 1);
        check("R7", "false GT on NaN does not halt", halted, 0);
        // flags hold without clear (R9)
        cond_sel = 5'd0; flag_nan = 1'b0; flag_z = 1'b0; instr_valid = 1'b1;
        @(negedge clk);
        instr_valid = 1'b0;
        check("R9", "sticky holds", siop_sticky, 1);
        done = 1;
    end

    initial begin
        for (int k = 0; k < 200000; k++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule